// File: doc/BRIEF.md
# Percent-Duty PWM Timer Channel

This block drives one pulse-width-modulated output from a plain clock. A clock divider turns the input clock into counter ticks, a period counter sweeps from zero to a programmable top value, and a compare threshold decides where in that sweep the output drops. The duty cycle is requested in whole percent. The block turns that request into a threshold itself, so the controlling logic never has to compute one.

Every setting passes through a pending stage and then a live stage. The live stage is loaded only when a period ends, so a change made in the middle of a period cannot shorten or split a pulse. The counter can run as a sawtooth (edge-aligned) or as a triangle (center-aligned). An enable input forces the pin to its idle level. A one-cycle pulse marks each period start, and the new settings take effect on that same cycle.

Top module: `pwm_pct_channel`

## Requirements
- R1: The counter advances once every (`div_sel`+1) clock cycles and holds its value between those advances.
- R2: In edge-aligned mode the counter runs 0,1,…,`top_sel` and then restarts at 0, so one period lasts (`top_sel`+1)·(`div_sel`+1) clock cycles.
- R3: The threshold is floor((`top_sel`+1)·pct/100). In edge-aligned mode the output is high for threshold·(`div_sel`+1) cycles at the start of each period and low for the rest. For example, top 999 with 25 % gives 250 high ticks.
- R4: A percent request above 100 behaves exactly like 100.
- R5: A request of 0 % keeps the output low for the whole period. A request of 100 % keeps it high for the whole period.
- R6: `div_sel`, `top_sel`, `duty_pct` and `center_sel` pass through a two-cycle registered mapping. They take effect only at a period boundary, so a change made in the middle of a period leaves the rest of that period unchanged.
- R7: In center-aligned mode (`center_sel`=1, `top_sel`≥1) the counter runs 0…`top_sel` and then `top_sel`−1…1, so a period lasts 2·`top_sel`·(`div_sel`+1) cycles. The output is high while the count is below the threshold, which gives a waveform symmetric about the top of the count.
- R8: While `out_en` is 0 the output stays at the idle level, which is low.
- R9: `period_start` is high for exactly one cycle at the start of each period. In that cycle the count is 0 and the new settings are live.
- R10: After reset the live threshold is 0, so the output is low and no period-start pulse is raised while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | DIV_W | Clock divide value minus one |
| top_sel | input | CNT_W | Counter top value |
| duty_pct | input | PCT_W | Duty request in percent; values above 100 are clamped |
| center_sel | input | 1 | 1 selects center-aligned counting |
| out_en | input | 1 | Output gate |
| pwm_out | output | 1 | PWM waveform |
| period_start | output | 1 | One-cycle pulse at each period start |

## Verification
The assertions assume that the live threshold and the live top value come from the same mapping stage, so the threshold never exceeds the top value plus one. They also assume that the count never starts above the top value, because every top-value change is loaded together with a count reset to zero. For center-aligned mode the assertions and the bench both assume a top value of at least one. The random stimulus draws top values from 1 to 100 and divide values from 0 to 3. Percent requests cover the full 7-bit range, so the clamp is exercised. The bench never samples a measured period until the mapping pipeline has settled and a whole period with the new settings has begun.

// File: rtl/pwm_pct_pkg.sv
package pwm_pct_pkg;
   typedef enum logic {CNT_UP = 1'b0, CNT_DOWN = 1'b1} cnt_dir_e;
   localparam int unsigned PCT_FULL = 100;
endpackage

// File: rtl/pwm_pct_mapper.sv
module pwm_pct_mapper #(
   parameter int unsigned DIV_W = 8,
   parameter int unsigned CNT_W = 10,
   parameter int unsigned PCT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_in,
   input  logic [CNT_W-1:0] top_in,
   input  logic [PCT_W-1:0] pct_in,
   input  logic             ctr_in,
   output logic [DIV_W-1:0] div_pend,
   output logic [CNT_W-1:0] top_pend,
   output logic [CNT_W:0]   thr_pend,
   output logic             ctr_pend
);
   import pwm_pct_pkg::*;
   localparam int unsigned PW = CNT_W + 1 + PCT_W;

   logic [PCT_W-1:0] pct_q;
   logic [CNT_W-1:0] top_q;
   logic [DIV_W-1:0] div_q;
   logic             ctr_q;
   logic [PW-1:0]    prod_c;
   logic [PW-1:0]    quo_c;
   logic [PCT_W-1:0] pct_clamped;

   always_comb begin
      if (PW'(pct_in) > PW'(PCT_FULL)) pct_clamped = PCT_W'(PCT_FULL);
      else                             pct_clamped = pct_in;
   end

   // stage 1: capture and clamp
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pct_q <= '0;
         top_q <= '0;
         div_q <= '0;
         ctr_q <= 1'b0;
      end else begin
         pct_q <= pct_clamped;
         top_q <= top_in;
         div_q <= div_in;
         ctr_q <= ctr_in;
      end
   end

   always_comb begin
      prod_c = (PW'(top_q) + PW'(1)) * PW'(pct_q);
      quo_c  = prod_c / PW'(PCT_FULL);
   end

   // stage 2: threshold result, kept aligned with its top value
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_pend <= '0;
         top_pend <= '0;
         div_pend <= '0;
         ctr_pend <= 1'b0;
      end else begin
         thr_pend <= quo_c[CNT_W:0];
         top_pend <= top_q;
         div_pend <= div_q;
         ctr_pend <= ctr_q;
      end
   end
endmodule

// File: rtl/pwm_tick_div.sv
module pwm_tick_div #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_act,
   output logic             tick
);
   logic [DIV_W-1:0] pre_cnt;

   assign tick = (pre_cnt >= div_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_cnt <= '0;
      else if (tick) pre_cnt <= '0;
      else           pre_cnt <= pre_cnt + DIV_W'(1);
   end
endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
   parameter int unsigned CNT_W     = 10,
   parameter bit          CENTER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] top_act,
   input  logic             ctr_act,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   import pwm_pct_pkg::*;
   cnt_dir_e dir;

   generate
      if (CENTER_EN) begin : g_center
         logic at_top, low_top;
         assign at_top  = (cnt >= top_act);
         assign low_top = (top_act <= CNT_W'(1));
         always_comb begin
            if (!ctr_act)            wrap = tick && at_top;
            else if (dir == CNT_UP)  wrap = tick && at_top && low_top;
            else                     wrap = tick && (cnt <= CNT_W'(1));
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
               dir <= CNT_UP;
            end else if (wrap) begin
               cnt <= '0;
               dir <= CNT_UP;
            end else if (tick) begin
               if (!ctr_act) begin
                  cnt <= cnt + CNT_W'(1);
               end else if (dir == CNT_UP) begin
                  if (at_top) begin
                     cnt <= cnt - CNT_W'(1);
                     dir <= CNT_DOWN;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
         end
      end else begin : g_edge_only
         assign wrap = tick && (cnt >= top_act);
         assign dir  = CNT_UP;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt <= '0;
            else if (wrap)  cnt <= '0;
            else if (tick)  cnt <= cnt + CNT_W'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/pwm_pct_channel.sv
module pwm_pct_channel #(
   parameter int unsigned DIV_W     = 8,
   parameter int unsigned CNT_W     = 10,
   parameter int unsigned PCT_W     = 7,
   parameter bit          CENTER_EN = 1'b1,
   parameter bit          ACT_HIGH  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_sel,
   input  logic [CNT_W-1:0] top_sel,
   input  logic [PCT_W-1:0] duty_pct,
   input  logic             center_sel,
   input  logic             out_en,
   output logic             pwm_out,
   output logic             period_start
);
   generate
      if (PCT_W < 7) begin : g_bad_pct
         $error("PCT_W must hold the value 100");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] div_pend, div_act;
   logic [CNT_W-1:0] top_pend, top_act;
   logic [CNT_W:0]   thr_pend, thr_act;
   logic             ctr_pend, ctr_act;
   logic             tick, wrap;
   logic [CNT_W-1:0] cnt;
   logic             below;

   pwm_pct_mapper #(.DIV_W(DIV_W), .CNT_W(CNT_W), .PCT_W(PCT_W)) u_map (
      .clk(clk), .rst_n(rst_n),
      .div_in(div_sel), .top_in(top_sel), .pct_in(duty_pct), .ctr_in(center_sel),
      .div_pend(div_pend), .top_pend(top_pend), .thr_pend(thr_pend), .ctr_pend(ctr_pend)
   );

   pwm_tick_div #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .div_act(div_act), .tick(tick)
   );

   pwm_period_cnt #(.CNT_W(CNT_W), .CENTER_EN(CENTER_EN)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .top_act(top_act),
      .ctr_act(ctr_act), .cnt(cnt), .wrap(wrap)
   );

   // live settings load only at a period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_act      <= '0;
         top_act      <= '0;
         thr_act      <= '0;
         ctr_act      <= 1'b0;
         period_start <= 1'b0;
      end else begin
         period_start <= wrap;
         if (wrap) begin
            div_act <= div_pend;
            top_act <= top_pend;
            thr_act <= thr_pend;
            ctr_act <= ctr_pend;
         end
      end
   end

   assign below = ({1'b0, cnt} < thr_act);

   generate
      if (ACT_HIGH) begin : g_pol_hi
         assign pwm_out = out_en & below;
      end else begin : g_pol_lo
         assign pwm_out = ~(out_en & below);
      end
   endgenerate
endmodule

// File: rtl/pwm_pct_channel_chk.sv
module pwm_pct_channel_chk #(
   parameter int unsigned CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] top_act,
   input logic [CNT_W:0]   thr_act,
   input logic             ctr_act,
   input logic             out_en,
   input logic             pwm_out,
   input logic             period_start
);
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= top_act);
   p_edge_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ctr_act && cnt < top_act) |=> (cnt == $past(cnt) + CNT_W'(1)));
   p_thr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, thr_act} <= ({2'b00, top_act} + (CNT_W+2)'(1)));
   p_full_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && thr_act > {1'b0, top_act}) |-> pwm_out);
   p_thr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !period_start |-> $stable(thr_act));
   p_top_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !period_start |-> $stable(top_act));
   p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> !pwm_out);
   p_start_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |-> (cnt == '0));
endmodule

bind pwm_pct_channel pwm_pct_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .top_act(top_act),
   .thr_act(thr_act), .ctr_act(ctr_act), .out_en(out_en),
   .pwm_out(pwm_out), .period_start(period_start)
);

// File: tb/pwm_pct_channel_test.sv
module pwm_pct_channel_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] div_sel = '0;
   logic [9:0] top_sel = '0;
   logic [6:0] duty_pct = '0;
   logic       center_sel = 1'b0;
   logic       out_en = 1'b0;
   logic       pwm_out, period_start;
   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pwm_pct_channel uut (
      .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .top_sel(top_sel),
      .duty_pct(duty_pct), .center_sel(center_sel), .out_en(out_en),
      .pwm_out(pwm_out), .period_start(period_start)
   );

   function automatic int exp_period(int dv, int tp, bit ct);
      if (ct) return 2 * tp * (dv + 1);
      return (tp + 1) * (dv + 1);
   endfunction

   function automatic int exp_high(int dv, int tp, int pct, bit ct, bit en);
      int p, thr, up, dn;
      if (!en) return 0;
      p   = (pct > 100) ? 100 : pct;
      thr = (tp + 1) * p / 100;
      up  = (thr < tp + 1) ? thr : tp + 1;
      if (!ct) return up * (dv + 1);
      dn  = ((thr < tp) ? thr : tp) - 1;
      if (dn < 0) dn = 0;
      return (up + dn) * (dv + 1);
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
      while (!period_start) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic measure(int chg_at, logic [6:0] chg_val, output int per, output int hi);
      while (!period_start) @(negedge clk);
      per = 0;
      hi  = 0;
      do begin
         if (pwm_out) hi++;
         per++;
         if (per == chg_at) duty_pct = chg_val;
         @(negedge clk);
      end while (!period_start);
   endtask

   task automatic run_case(int dv, int tp, int pct, bit ct, bit en, string tag);
      int per, hi;
      div_sel = 8'(dv); top_sel = 10'(tp); duty_pct = 7'(pct);
      center_sel = ct; out_en = en;
      settle();
      measure(-1, 7'd0, per, hi);
      check(per == exp_period(dv, tp, ct), {tag, " period"}, per, exp_period(dv, tp, ct));
      check(hi == exp_high(dv, tp, pct, ct, en), {tag, " high"}, hi, exp_high(dv, tp, pct, ct, en));
   endtask

   initial begin : watchdog
      wait (cyc >= 190000);
      failures++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int per, hi;
      void'($urandom(32'd4242));
      out_en = 1'b1; duty_pct = 7'd50; top_sel = 10'd9;
      repeat (4) @(negedge clk);
      // R10: held reset keeps output low and no start pulse
      check(pwm_out == 1'b0, "R10 output in reset", pwm_out, 0);
      check(period_start == 1'b0, "R10 start in reset", period_start, 0);
      rst_n = 1'b1;

      run_case(0, 999, 25, 0, 1, "R3 top999 25pct");
      run_case(0, 999, 50, 0, 1, "R3 top999 50pct");
      run_case(3, 9, 30, 0, 1, "R1 div3 top9");
      run_case(0, 49, 0, 0, 1, "R5 zero pct");
      run_case(0, 49, 100, 0, 1, "R5 full pct");
      run_case(0, 49, 120, 0, 1, "R4 clamp 120");
      run_case(1, 10, 50, 1, 1, "R7 center half");
      run_case(0, 10, 100, 1, 1, "R7 center full");
      run_case(0, 1, 50, 1, 1, "R7 center top1");
      run_case(0, 30, 60, 0, 0, "R8 gated");
      run_case(0, 0, 100, 0, 1, "R2 top0");

      // R6: mid-period duty change must wait for the boundary
      run_case(0, 99, 20, 0, 1, "R6 base");
      measure(3, 7'd80, per, hi);
      check(hi == 20, "R6 old duty kept", hi, 20);
      measure(-1, 7'd0, per, hi);
      check(hi == 80, "R6 new duty next period", hi, 80);

      // R9: start pulse lasts one cycle
      run_case(0, 9, 40, 0, 1, "R9 base");
      @(negedge clk);
      check(period_start == 1'b0, "R9 one-cycle pulse", period_start, 0);

      for (int i = 0; i < 24; i++) begin
         int dv, tp, pc;
         bit ct;
         dv = int'($urandom % 4);
         tp = 1 + int'($urandom % 100);
         pc = int'($urandom % 128);
         ct = 1'($urandom % 2);
         run_case(dv, tp, pc, ct, 1, ct ? "R7 random" : "R3 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule